// File: doc/BRIEF.md
# Disk Function Interrupt Status and Clear Register

This block collects the two interrupt sources of a disk transfer function, a transfer-done event and a bus/memory error event, into sticky pending bits. Software sees them through a small word-indexed register window: a status word that shows the raw pending bits, an enable-set word whose one bits turn sources on, and a write-one-to-clear word that drops pending bits. The interrupt output is raised while any pending bit has its source enabled. Either pending bit being set is a valid interrupt.

When an error event arrives, the block also records the 64-bit address that the failing access carried. The address is held from the first error until the error pending bit is cleared, and it is read as two 32-bit words. Reading the device status register while the device reports not-busy acts as a second clear path: all pending bits drop as a side effect of that read.

All register access is a plain single-cycle write strobe with a combinational read of the indexed word; there is no stream data path, so no valid/ready handshake is used.

Top module: `intr_stat_ctl`

## Requirements
- R1: After reset all pending bits, all enable bits, both error-address words and the interrupt output are zero.
- R2: A done pulse sets pending bit 0 and an error pulse sets pending bit 1; reading word index 3 returns the pending bits in bits [1:0] and zero above, visible in the cycle after the pulse's clock edge.
- R3: A write to word index 5 sets every enable bit whose data bit is 1 and leaves the rest unchanged (zeros never disable); reading index 5 returns the enable bits.
- R4: The interrupt output is high exactly when some pending bit has its enable bit set.
- R5: A write to word index 7 clears each pending bit whose data bit is 1; bits written 0 keep their value.
- R6: An event pulse in the same cycle as a clear of its bit (by write or by status read) wins: the bit ends up set.
- R7: A device status read pulse with the busy input low clears all pending bits; with busy high it has no effect.
- R8: An error pulse while pending bit 1 is clear stores the error address; word index 0 returns its low 32 bits and index 1 its high 32 bits.
- R9: Further error pulses do not change the stored address until pending bit 1 is cleared; an error pulse in the same cycle as that clear stores its address.
- R10: Writes to any index other than 5 and 7 (including the status word at 3) change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Word index for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the indexed word |
| done_evt | input | 1 | Transfer-done event pulse |
| err_evt | input | 1 | Bus/memory error event pulse |
| err_addr | input | 64 | Address of the failing access, valid with err_evt |
| dev_stat_rd | input | 1 | Pulse marking a read of the device status register |
| dev_busy | input | 1 | Busy bit of the device status at that read |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume event, write and status-read inputs are single-cycle pulses sampled at the rising edge, and that err_addr is meaningful only while err_evt is high. The stimulus drives every input at the falling edge and returns pulses to zero after one cycle, so no pulse is seen twice. Same-cycle collisions of events with write clears and with the not-busy status read are driven on purpose, because those are the cases where the clear priority and the address capture rule matter.

// File: rtl/intr_stat_pkg.sv
package intr_stat_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned EADDR_W = 64;

  // word indices; software relies on these positions
  localparam logic [IDX_W-1:0] IDX_EADR_LO = 3'd0;
  localparam logic [IDX_W-1:0] IDX_EADR_HI = 3'd1;
  localparam logic [IDX_W-1:0] IDX_STATUS  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_ENSET   = 3'd5;
  localparam logic [IDX_W-1:0] IDX_CLEAR   = 3'd7;

  // source bit positions
  localparam int unsigned SRC_DONE = 0;
  localparam int unsigned SRC_ERR  = 1;
endpackage

// File: rtl/intr_reg_decode.sv
module intr_reg_decode
  import intr_stat_pkg::*;
#(
  parameter int unsigned DW   = REG_W,
  parameter int unsigned AW   = IDX_W,
  parameter int unsigned NSRC = NUM_SRC,
  parameter int unsigned EAW  = EADDR_W
) (
  input  logic            wr,
  input  logic [AW-1:0]   idx,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] enab,
  input  logic [EAW-1:0]  cap_addr,
  output logic [NSRC-1:0] set_mask,
  output logic [NSRC-1:0] clr_mask,
  output logic [DW-1:0]   rdata
);
  localparam int unsigned HI_W = EAW - DW;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    if (wr && idx == IDX_ENSET) set_mask = wdata[NSRC-1:0];
    if (wr && idx == IDX_CLEAR) clr_mask = wdata[NSRC-1:0];
  end

  always_comb begin
    rdata = '0;
    unique case (idx)
      IDX_EADR_LO: rdata = cap_addr[DW-1:0];
      IDX_EADR_HI: rdata[HI_W-1:0] = cap_addr[EAW-1:DW];
      IDX_STATUS:  rdata[NSRC-1:0] = pend;
      IDX_ENSET:   rdata[NSRC-1:0] = enab;
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/intr_pending_bank.sv
module intr_pending_bank
  import intr_stat_pkg::*;
#(
  parameter int unsigned NSRC = NUM_SRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] clr_mask,
  input  logic            flush,
  input  logic [NSRC-1:0] set_mask,
  output logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] enab
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic clr_g;
    assign clr_g = clr_mask[g] | flush;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[g] <= 1'b0;
        enab[g] <= 1'b0;
      end else begin
        pend[g] <= (pend[g] & ~clr_g) | evt[g];
        if (set_mask[g]) enab[g] <= 1'b1;
      end
    end

    // R6
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[g] |=> pend[g]);
    // R5
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_g && !evt[g]) |=> !pend[g]);
    // R3
    enab_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enab[g] |=> enab[g]);
  end
endmodule

// File: rtl/intr_err_capture.sv
module intr_err_capture
  import intr_stat_pkg::*;
#(
  parameter int unsigned EAW = EADDR_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           err_evt,
  input  logic           err_pend,
  input  logic           err_clr,
  input  logic [EAW-1:0] evt_addr,
  output logic [EAW-1:0] cap_addr
);
  logic open_slot;
  assign open_slot = !err_pend || err_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cap_addr <= '0;
    else if (err_evt && open_slot) cap_addr <= evt_addr;
  end

  // R8
  first_err_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !err_pend) |=> cap_addr == $past(evt_addr));
  // R9
  held_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pend && !err_clr) |=> $stable(cap_addr));
endmodule

// File: rtl/intr_stat_ctl.sv
module intr_stat_ctl
  import intr_stat_pkg::*;
#(
  parameter int unsigned DW   = REG_W,
  parameter int unsigned AW   = IDX_W,
  parameter int unsigned EAW  = EADDR_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_idx,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic           done_evt,
  input  logic           err_evt,
  input  logic [EAW-1:0] err_addr,
  input  logic           dev_stat_rd,
  input  logic           dev_busy,
  output logic           irq
);
  localparam int unsigned NSRC = NUM_SRC;

  logic [NSRC-1:0] evt_vec, pend, enab, set_mask, clr_mask;
  logic [EAW-1:0]  cap_addr;
  logic            flush;

  always_comb begin
    evt_vec = '0;
    evt_vec[SRC_DONE] = done_evt;
    evt_vec[SRC_ERR]  = err_evt;
  end

  assign flush = dev_stat_rd & ~dev_busy;

  intr_reg_decode #(.DW(DW), .AW(AW), .NSRC(NSRC), .EAW(EAW)) u_dec (
    .wr(reg_wr), .idx(reg_idx), .wdata(reg_wdata),
    .pend(pend), .enab(enab), .cap_addr(cap_addr),
    .set_mask(set_mask), .clr_mask(clr_mask), .rdata(reg_rdata)
  );

  intr_pending_bank #(.NSRC(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .evt(evt_vec), .clr_mask(clr_mask),
    .flush(flush), .set_mask(set_mask), .pend(pend), .enab(enab)
  );

  intr_err_capture #(.EAW(EAW)) u_cap (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .err_pend(pend[SRC_ERR]),
    .err_clr(clr_mask[SRC_ERR] | flush), .evt_addr(err_addr),
    .cap_addr(cap_addr)
  );

  assign irq = |(pend & enab);

  // R7
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_stat_rd && !dev_busy && !done_evt && !err_evt) |=> pend == '0);
  // R7
  busy_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_stat_rd && dev_busy && !reg_wr) |=> (pend & $past(pend)) == $past(pend));
  // R10
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx != IDX_ENSET) |=> $stable(enab));
endmodule

// File: tb/intr_stat_ctl_test.sv
module intr_stat_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        done_evt = 1'b0, err_evt = 1'b0;
  logic [63:0] err_addr = '0;
  logic        dev_stat_rd = 1'b0, dev_busy = 1'b0;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  typedef struct { bit is_irq; logic [31:0] exp; string req; } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  intr_stat_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done_evt(done_evt),
    .err_evt(err_evt), .err_addr(err_addr), .dev_stat_rd(dev_stat_rd),
    .dev_busy(dev_busy), .irq(irq)
  );

  // monitor: compares one expected item per falling edge, 1 ns after
  initial forever begin
    @(negedge clk); #1;
    if (sb.size() > 0) begin
      exp_t e;
      logic [31:0] act;
      e = sb.pop_front();
      act = e.is_irq ? {31'd0, irq} : reg_rdata;
      n_chk++;
      if (act !== e.exp) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", e.req, act, e.exp);
      end
    end
  end

  task automatic expect_rd(input logic [2:0] idx, input logic [31:0] v, input string req);
    @(negedge clk);
    reg_idx = idx;
    sb.push_back('{1'b0, v, req});
  endtask

  task automatic expect_irq(input logic v, input string req);
    @(negedge clk);
    sb.push_back('{1'b1, {31'd0, v}, req});
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic dn, input logic er, input logic [63:0] a);
    @(negedge clk);
    done_evt = dn; err_evt = er; err_addr = a;
    @(negedge clk);
    done_evt = 1'b0; err_evt = 1'b0;
  endtask

  task automatic stat_read(input logic busy);
    @(negedge clk);
    dev_stat_rd = 1'b1; dev_busy = busy;
    @(negedge clk);
    dev_stat_rd = 1'b0; dev_busy = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  localparam logic [63:0] ADDR_A = 64'h1234_5678_9ABC_DEF0;
  localparam logic [63:0] ADDR_B = 64'h0BAD_F00D_5555_AAAA;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_rd(3'd3, 32'h0, "R1 status");
    expect_rd(3'd5, 32'h0, "R1 enable");
    expect_rd(3'd0, 32'h0, "R1 addr lo");
    expect_rd(3'd1, 32'h0, "R1 addr hi");
    expect_irq(1'b0, "R1 irq");

    // R2 done event, not enabled
    pulse(1'b1, 1'b0, '0);
    expect_rd(3'd3, 32'h1, "R2 done bit");
    expect_irq(1'b0, "R4 masked");

    // R3 / R4 enable
    wr(3'd5, 32'h1);
    expect_rd(3'd5, 32'h1, "R3 enable set");
    expect_irq(1'b1, "R4 enabled irq");
    wr(3'd5, 32'h2);
    expect_rd(3'd5, 32'h3, "R3 zeros keep");

    // R5 clear
    wr(3'd7, 32'h2);
    expect_rd(3'd3, 32'h1, "R5 other bit kept");
    wr(3'd7, 32'h1);
    expect_rd(3'd3, 32'h0, "R5 cleared");
    expect_irq(1'b0, "R4 irq drops");

    // R8 error capture
    pulse(1'b0, 1'b1, ADDR_A);
    expect_rd(3'd3, 32'h2, "R2 err bit");
    expect_irq(1'b1, "R4 err irq");
    expect_rd(3'd0, ADDR_A[31:0], "R8 addr lo");
    expect_rd(3'd1, ADDR_A[63:32], "R8 addr hi");

    // R9 second error keeps first address
    pulse(1'b0, 1'b1, ADDR_B);
    expect_rd(3'd0, ADDR_A[31:0], "R9 held lo");
    expect_rd(3'd1, ADDR_A[63:32], "R9 held hi");

    // R10 stray writes
    wr(3'd3, 32'h0);
    expect_rd(3'd3, 32'h2, "R10 status write ignored");
    wr(3'd2, 32'hFFFF_FFFF);
    expect_rd(3'd5, 32'h3, "R10 enable untouched");
    expect_rd(3'd3, 32'h2, "R10 pending untouched");
    wr(3'd0, 32'h0);
    expect_rd(3'd0, ADDR_A[31:0], "R10 addr write ignored");

    // R7 status read side effect
    stat_read(1'b1);
    expect_rd(3'd3, 32'h2, "R7 busy no effect");
    stat_read(1'b0);
    expect_rd(3'd3, 32'h0, "R7 not busy clears");
    expect_irq(1'b0, "R7 irq low");

    // R6 / R9 error with same-cycle clear; first set bit 1 again
    pulse(1'b0, 1'b1, ADDR_A);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = 3'd7; reg_wdata = 32'h3;
    err_evt = 1'b1; err_addr = ADDR_B;
    @(negedge clk);
    reg_wr = 1'b0; err_evt = 1'b0;
    expect_rd(3'd3, 32'h2, "R6 event beats write clear");
    expect_rd(3'd0, ADDR_B[31:0], "R9 capture on clear");
    expect_rd(3'd1, ADDR_B[63:32], "R9 capture on clear hi");

    // R6 / R7 done event with same-cycle not-busy status read
    @(negedge clk);
    dev_stat_rd = 1'b1; dev_busy = 1'b0; done_evt = 1'b1;
    @(negedge clk);
    dev_stat_rd = 1'b0; done_evt = 1'b0;
    expect_rd(3'd3, 32'h1, "R6 event beats status-read clear");
    expect_irq(1'b1, "R4 irq after collision");

    repeat (3) @(negedge clk);
    done_flag = 1;
    finish_run();
  end
endmodule